// File: doc/BRIEF.md
# Exposure and Readout Shutter Sequencer

This block sequences one still capture on an image sensor. Firmware loads a few settings through a small register-write port and then writes a trigger mask. At the next field sync the block starts an exposure phase, which lasts a programmed number of fields. A readout phase of a programmed number of fields follows, and then the block returns to idle. While a capture runs, the block gates the substrate-clear pulses and the sensor-gate pulses. It also drives three outputs, for the flash strobe, the mechanical shutter and the substrate bias, at programmed positions inside the field.

A position is a line number and a pixel number. The line number counts line strobes since the last field strobe. The pixel number comes from an external horizontal counter. Register writes go into a staging copy, and that copy becomes the working copy only on a field sync strobe. Settings can therefore be changed mid-field without disturbing the field in progress. The write port is a plain control path: each write is taken in the cycle in which `wr_en_i` is high, and the port never back-pressures. The sync inputs are single-cycle strobes that mark the falling edges of the field and line syncs.

Top module: `capture_shutter_seq`

## Requirements
- R1: Writes to the count (addr 0, 1), position (addr 3 to 6) and substrate-mode (addr 7) registers land in a staging copy. A trigger write (addr 2) and a shutter-reopen write (addr 8) only arm a request. None of these affects any output until the next cycle with `vd_fall_i` high, when all of them take effect together.
- R2: A trigger written while idle starts a capture at the next field strobe. From the following cycle, `busy_o` is 1 and `subck_en_o` and `vsg_en_o` are 0.
- R3: The exposure phase lasts max(E,1) fields, where E is the value at addr 0. It is followed by a readout phase of max(R,1) fields, where R is the value at addr 1. In exposure, `vsg_en_o`=0. In readout, `vsg_en_o`=1 and `vsg_readout_o`=1. In both phases, `subck_en_o`=0. Each phase change happens on the cycle after a field strobe.
- R4: When readout ends, `busy_o` drops and `subck_en_o` returns to 1. `vsg_en_o`=1 and `vsg_readout_o`=0 give preview timing. `strobe_o` and `vsub_o` go to 0 in that same cycle.
- R5: With trigger bit 0 set, `strobe_o` rises one cycle after the strobe-on position (addr 3) is hit during exposure. It falls one cycle after the strobe-off position (addr 4) is hit during the capture. Off wins when both positions are hit in the same cycle.
- R6: With trigger bit 1 set, `mshut_o` (1 = open) drops one cycle after the shutter-close position (addr 5) is hit during a capture. It stays 0, including after the capture, until a reopen write (addr 8) takes effect at a field strobe.
- R7: With trigger bit 2 set and substrate mode 0 (addr 7 bit 0), `vsub_o` rises one cycle after the substrate-on position (addr 6) is hit. With mode 1, it rises in the cycle the capture starts.
- R8: Trigger bits that are 0 leave their outputs idle for the whole capture: strobe 0, shutter 1, substrate 0.
- R9: A trigger write that arrives while `busy_o` is 1 is discarded and does not start a later capture.
- R10: After reset: `busy_o`=0, `subck_en_o`=1, `vsg_en_o`=1, `vsg_readout_o`=0, `strobe_o`=0, `mshut_o`=1, `vsub_o`=0.
- R11: Position data is {line[LINE_W-1:0], pixel[PIX_W-1:0]}, with the line number in the upper bits. A position is hit when the line count equals the line field and `pix_cnt_i` equals the pixel field. The line count is cleared by `vd_fall_i` and is advanced by each `hd_fall_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vd_fall_i | input | 1 | Field sync falling-edge strobe |
| hd_fall_i | input | 1 | Line sync falling-edge strobe |
| pix_cnt_i | input | PIX_W | Pixel position within the line |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register address |
| wr_data_i | input | LINE_W+PIX_W | Register write data |
| busy_o | output | 1 | Capture in progress |
| subck_en_o | output | 1 | Substrate-clear pulses allowed |
| vsg_en_o | output | 1 | Sensor-gate pulses allowed |
| vsg_readout_o | output | 1 | Sensor gates use the readout pattern |
| strobe_o | output | 1 | Flash strobe, 1 = on |
| mshut_o | output | 1 | Mechanical shutter, 1 = open |
| vsub_o | output | 1 | Substrate bias, 1 = active |

## Verification
The assertions check, on every cycle, that a capture starts and its phases change only after a field strobe, and that the shutter reopens only after one. They also check that strobe and substrate stay low whenever the block is idle, and that a strobe disabled by the trigger mask never turns on. Only the bench's scenarios can show the rest. That covers field counts of zero and one, exact toggle positions, off-over-on priority and the two substrate modes. It also covers the shutter staying closed after a capture, staging of mid-field writes, and a trigger written during a capture being dropped.

// File: rtl/shseq_pkg.sv
package shseq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_EXPOSE  = 2'd1,
    PH_READOUT = 2'd2
  } phase_e;

  // register addresses
  localparam int unsigned REG_EXP        = 0;
  localparam int unsigned REG_RDO        = 1;
  localparam int unsigned REG_TRIG       = 2;
  localparam int unsigned REG_POS_BASE   = 3;  // four position registers follow
  localparam int unsigned REG_SUB_MODE   = 7;
  localparam int unsigned REG_SHUT_OPEN  = 8;

  // position slots
  localparam int unsigned N_POS       = 4;
  localparam int unsigned POS_STB_ON  = 0;
  localparam int unsigned POS_STB_OFF = 1;
  localparam int unsigned POS_SHUT    = 2;
  localparam int unsigned POS_SUB     = 3;

  // trigger mask bits
  localparam int unsigned MB_STROBE = 0;
  localparam int unsigned MB_SHUT   = 1;
  localparam int unsigned MB_SUB    = 2;

endpackage

// File: rtl/shseq_regs.sv
module shseq_regs
  import shseq_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned FLD_W  = 4,
  parameter int unsigned POS_W  = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [POS_W-1:0]  wr_data,
  input  logic              vd_fall,
  input  logic              busy,
  input  logic              start,
  output logic [FLD_W-1:0]  sh_exp,
  output logic [FLD_W-1:0]  sh_rdo,
  output logic              sub_early,
  output logic              trig_pend,
  output logic              reopen_go,
  output logic [2:0]        act_mask,
  output logic              act_mode,
  output logic [POS_W-1:0]  act_pos [N_POS]
);

  logic [2:0] sh_mask;
  logic       sh_mode;
  logic       reopen_pend;

  function automatic logic hit_addr(input logic [ADDR_W-1:0] a, input int unsigned r);
    return a == ADDR_W'(r);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_exp      <= '0;
      sh_rdo      <= '0;
      sh_mask     <= '0;
      sh_mode     <= 1'b0;
      trig_pend   <= 1'b0;
      reopen_pend <= 1'b0;
      act_mask    <= '0;
      act_mode    <= 1'b0;
    end else begin
      if (vd_fall) begin
        trig_pend   <= 1'b0;
        reopen_pend <= 1'b0;
        act_mode    <= sh_mode;
      end
      if (start) act_mask <= sh_mask;
      if (wr_en) begin
        if (hit_addr(wr_addr, REG_EXP))      sh_exp  <= wr_data[FLD_W-1:0];
        if (hit_addr(wr_addr, REG_RDO))      sh_rdo  <= wr_data[FLD_W-1:0];
        if (hit_addr(wr_addr, REG_SUB_MODE)) sh_mode <= wr_data[0];
        if (hit_addr(wr_addr, REG_SHUT_OPEN)) reopen_pend <= 1'b1;
        if (hit_addr(wr_addr, REG_TRIG) && !busy) begin
          sh_mask   <= wr_data[2:0];
          trig_pend <= 1'b1;
        end
      end
    end
  end

  assign sub_early = sh_mask[MB_SUB] & sh_mode;
  assign reopen_go = vd_fall & reopen_pend;

  for (genvar gi = 0; gi < N_POS; gi++) begin : g_pos
    logic [POS_W-1:0] stage_q;
    logic [POS_W-1:0] work_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q <= '0;
        work_q  <= '0;
      end else begin
        if (wr_en && hit_addr(wr_addr, REG_POS_BASE + gi)) stage_q <= wr_data;
        if (vd_fall) work_q <= stage_q;
      end
    end
    assign act_pos[gi] = work_q;
  end

endmodule

// File: rtl/shseq_phase.sv
module shseq_phase
  import shseq_pkg::*;
#(
  parameter int unsigned FLD_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vd_fall,
  input  logic             trig_pend,
  input  logic [FLD_W-1:0] sh_exp,
  input  logic [FLD_W-1:0] sh_rdo,
  output phase_e           phase,
  output logic             start,
  output logic             finish
);

  logic [FLD_W-1:0] cnt_q;
  logic             last_fld;

  assign last_fld = (cnt_q <= FLD_W'(1));

  always_comb begin
    start  = vd_fall && (phase == PH_IDLE) && trig_pend;
    finish = vd_fall && (phase == PH_READOUT) && last_fld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt_q <= '0;
    end else if (vd_fall) begin
      case (phase)
        PH_IDLE: begin
          if (trig_pend) begin
            phase <= PH_EXPOSE;
            cnt_q <= sh_exp;
          end
        end
        PH_EXPOSE: begin
          if (last_fld) begin
            phase <= PH_READOUT;
            cnt_q <= sh_rdo;
          end else begin
            cnt_q <= cnt_q - FLD_W'(1);
          end
        end
        PH_READOUT: begin
          if (last_fld) phase <= PH_IDLE;
          else          cnt_q <= cnt_q - FLD_W'(1);
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/shseq_pos.sv
module shseq_pos
  import shseq_pkg::*;
#(
  parameter int unsigned LINE_W = 11,
  parameter int unsigned PIX_W  = 12,
  localparam int unsigned POS_W = LINE_W + PIX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vd_fall,
  input  logic              hd_fall,
  input  logic [PIX_W-1:0]  pix_cnt,
  input  logic [POS_W-1:0]  act_pos [N_POS],
  output logic [N_POS-1:0]  hit
);

  logic [LINE_W-1:0] line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       line_q <= '0;
    else if (vd_fall) line_q <= '0;
    else if (hd_fall) line_q <= line_q + LINE_W'(1);
  end

  for (genvar gi = 0; gi < N_POS; gi++) begin : g_cmp
    assign hit[gi] = (act_pos[gi][POS_W-1:PIX_W] == line_q) &&
                     (act_pos[gi][PIX_W-1:0] == pix_cnt);
  end

endmodule

// File: rtl/shseq_outs.sv
module shseq_outs
  import shseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  phase_e           phase,
  input  logic             start,
  input  logic             finish,
  input  logic             reopen_go,
  input  logic [N_POS-1:0] hit,
  input  logic [2:0]       act_mask,
  input  logic             act_mode,
  input  logic             sub_early,
  output logic             strobe,
  output logic             mshut,
  output logic             vsub
);

  logic busy;
  logic stop;

  assign busy = (phase != PH_IDLE);
  assign stop = !busy || finish;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe <= 1'b0;
      mshut  <= 1'b1;
      vsub   <= 1'b0;
    end else begin
      // flash strobe: off position wins over on position
      if (stop)
        strobe <= 1'b0;
      else if (act_mask[MB_STROBE] && hit[POS_STB_OFF])
        strobe <= 1'b0;
      else if (act_mask[MB_STROBE] && hit[POS_STB_ON] && phase == PH_EXPOSE)
        strobe <= 1'b1;

      // substrate bias
      if (start && sub_early)
        vsub <= 1'b1;
      else if (stop)
        vsub <= 1'b0;
      else if (act_mask[MB_SUB] && !act_mode && hit[POS_SUB])
        vsub <= 1'b1;

      // mechanical shutter: closed until an explicit reopen
      if (reopen_go)
        mshut <= 1'b1;
      else if (busy && act_mask[MB_SHUT] && hit[POS_SHUT])
        mshut <= 1'b0;
    end
  end

endmodule

// File: rtl/capture_shutter_seq.sv
module capture_shutter_seq
  import shseq_pkg::*;
#(
  parameter int unsigned LINE_W = 11,
  parameter int unsigned PIX_W  = 12,
  parameter int unsigned FLD_W  = 4,
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned POS_W = LINE_W + PIX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vd_fall_i,
  input  logic              hd_fall_i,
  input  logic [PIX_W-1:0]  pix_cnt_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [POS_W-1:0]  wr_data_i,
  output logic              busy_o,
  output logic              subck_en_o,
  output logic              vsg_en_o,
  output logic              vsg_readout_o,
  output logic              strobe_o,
  output logic              mshut_o,
  output logic              vsub_o
);

  logic [FLD_W-1:0] sh_exp;
  logic [FLD_W-1:0] sh_rdo;
  logic             sub_early;
  logic             trig_pend;
  logic             reopen_go;
  logic [2:0]       act_mask;
  logic             act_mode;
  logic [POS_W-1:0] act_pos [N_POS];
  logic [N_POS-1:0] hit;
  phase_e           phase;
  logic             start;
  logic             finish;

  shseq_regs #(.ADDR_W(ADDR_W), .FLD_W(FLD_W), .POS_W(POS_W)) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en_i),
    .wr_addr   (wr_addr_i),
    .wr_data   (wr_data_i),
    .vd_fall   (vd_fall_i),
    .busy      (busy_o),
    .start     (start),
    .sh_exp    (sh_exp),
    .sh_rdo    (sh_rdo),
    .sub_early (sub_early),
    .trig_pend (trig_pend),
    .reopen_go (reopen_go),
    .act_mask  (act_mask),
    .act_mode  (act_mode),
    .act_pos   (act_pos)
  );

  shseq_phase #(.FLD_W(FLD_W)) phase_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .vd_fall   (vd_fall_i),
    .trig_pend (trig_pend),
    .sh_exp    (sh_exp),
    .sh_rdo    (sh_rdo),
    .phase     (phase),
    .start     (start),
    .finish    (finish)
  );

  shseq_pos #(.LINE_W(LINE_W), .PIX_W(PIX_W)) pos_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .vd_fall (vd_fall_i),
    .hd_fall (hd_fall_i),
    .pix_cnt (pix_cnt_i),
    .act_pos (act_pos),
    .hit     (hit)
  );

  shseq_outs outs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase     (phase),
    .start     (start),
    .finish    (finish),
    .reopen_go (reopen_go),
    .hit       (hit),
    .act_mask  (act_mask),
    .act_mode  (act_mode),
    .sub_early (sub_early),
    .strobe    (strobe_o),
    .mshut     (mshut_o),
    .vsub      (vsub_o)
  );

  assign busy_o        = (phase != PH_IDLE);
  assign subck_en_o    = (phase == PH_IDLE);
  assign vsg_en_o      = (phase != PH_EXPOSE);
  assign vsg_readout_o = (phase == PH_READOUT);

endmodule

// File: rtl/shseq_chk.sv
module shseq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       vd_fall,
  input logic       busy,
  input logic       vsg_en,
  input logic       strobe,
  input logic       mshut,
  input logic       vsub,
  input logic [2:0] act_mask
);

  // R2
  start_on_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(vd_fall));

  // R3
  phase_on_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vsg_en) |-> $past(vd_fall));

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!strobe && !vsub));

  // R6
  reopen_on_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mshut) |-> $past(vd_fall));

  // R8
  strobe_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !act_mask[0]) |-> !strobe);

endmodule

bind capture_shutter_seq shseq_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .vd_fall  (vd_fall_i),
  .busy     (busy_o),
  .vsg_en   (vsg_en_o),
  .strobe   (strobe_o),
  .mshut    (mshut_o),
  .vsub     (vsub_o),
  .act_mask (act_mask)
);

// File: tb/capture_shutter_seq_tb_top.sv
module capture_shutter_seq_tb_top;

  localparam int CLK_P    = 10;
  localparam int NL       = 5;   // lines per field in the bench
  localparam int NP       = 8;   // pixels per line in the bench
  localparam int IDLE_PIX = 11;  // pixel value never used by a position

  typedef struct packed {
    logic [3:0] e;
    logic [3:0] r;
    logic [2:0] m;
    logic       md;
    logic [7:0] son;
    logic [7:0] soff;
    logic [7:0] shc;
    logic [7:0] von;
  } vec_t;

  // positions packed as {line[3:0], pixel[3:0]}
  localparam vec_t VECS [4] = '{
    '{4'd2, 4'd2, 3'b111, 1'b0, 8'h12, 8'h35, 8'h24, 8'h16},
    '{4'd1, 4'd1, 3'b001, 1'b1, 8'h20, 8'h20, 8'h00, 8'h00},
    '{4'd0, 4'd3, 3'b110, 1'b1, 8'h13, 8'h33, 8'h41, 8'h00},
    '{4'd3, 4'd0, 3'b000, 1'b0, 8'h11, 8'h37, 8'h22, 8'h23}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vd = 1'b0, hd = 1'b0, we = 1'b0;
  logic [11:0] pix = '0;
  logic [3:0]  addr = '0;
  logic [22:0] data = '0;
  logic busy, subck, vsg, vsgr, strobe, mshut, vsub;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench model state
  int          m_st = 0;
  logic [3:0]  m_cnt = '0, m_sh_e = '0, m_sh_r = '0;
  logic [2:0]  m_sh_m = '0, m_act_m = '0;
  logic        m_sh_md = 1'b0, m_act_md = 1'b0;
  logic [22:0] m_sh_p [4] = '{default: '0};
  logic [22:0] m_act_p [4] = '{default: '0};
  int          m_line = 0;
  logic        m_pt = 1'b0, m_pr = 1'b0;
  logic        m_strobe = 1'b0, m_mshut = 1'b1, m_vsub = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  capture_shutter_seq dut_i (
    .clk(clk), .rst_n(rst_n), .vd_fall_i(vd), .hd_fall_i(hd), .pix_cnt_i(pix),
    .wr_en_i(we), .wr_addr_i(addr), .wr_data_i(data),
    .busy_o(busy), .subck_en_o(subck), .vsg_en_o(vsg), .vsg_readout_o(vsgr),
    .strobe_o(strobe), .mshut_o(mshut), .vsub_o(vsub)
  );

  function automatic logic [22:0] pos8(input logic [7:0] v);
    return {7'd0, v[7:4], 8'd0, v[3:0]};
  endfunction

  function automatic int max1(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  task automatic chk(input logic got, input logic exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, got, exp, $time);
    end
  endtask

  // expected behaviour at one clock edge, from the requirements
  task automatic model_edge(input logic v, input logic h, input int p,
                            input logic w, input int a, input logic [22:0] d);
    logic b, st, fin, stop;
    logic [3:0] ht;
    b    = (m_st != 0);
    st   = v && (m_st == 0) && m_pt;
    fin  = v && (m_st == 2) && (m_cnt <= 4'd1);
    stop = !b || fin;
    for (int i = 0; i < 4; i++)
      ht[i] = (m_act_p[i][22:12] == 11'(m_line)) && (m_act_p[i][11:0] == 12'(p));
    if (stop) m_strobe = 1'b0;
    else if (m_act_m[0] && ht[1]) m_strobe = 1'b0;
    else if (m_act_m[0] && ht[0] && m_st == 1) m_strobe = 1'b1;
    if (st && m_sh_m[2] && m_sh_md) m_vsub = 1'b1;
    else if (stop) m_vsub = 1'b0;
    else if (m_act_m[2] && !m_act_md && ht[3]) m_vsub = 1'b1;
    if (v && m_pr) m_mshut = 1'b1;
    else if (b && m_act_m[1] && ht[2]) m_mshut = 1'b0;
    if (v) begin
      if (m_st == 0) begin
        if (m_pt) begin m_st = 1; m_cnt = m_sh_e; end
      end else if (m_st == 1) begin
        if (m_cnt <= 4'd1) begin m_st = 2; m_cnt = m_sh_r; end
        else m_cnt = m_cnt - 4'd1;
      end else begin
        if (m_cnt <= 4'd1) m_st = 0;
        else m_cnt = m_cnt - 4'd1;
      end
      if (st) m_act_m = m_sh_m;
      m_act_md = m_sh_md;
      for (int i = 0; i < 4; i++) m_act_p[i] = m_sh_p[i];
      m_pt = 1'b0;
      m_pr = 1'b0;
      m_line = 0;
    end else if (h) begin
      m_line = m_line + 1;
    end
    if (w) begin
      case (a)
        0: m_sh_e = d[3:0];
        1: m_sh_r = d[3:0];
        2: if (!b) begin m_sh_m = d[2:0]; m_pt = 1'b1; end
        3, 4, 5, 6: m_sh_p[a-3] = d;
        7: m_sh_md = d[0];
        8: m_pr = 1'b1;
        default: ;
      endcase
    end
  endtask

  task automatic compare_all();
    chk(busy,   m_st != 0, "R3 busy");
    chk(subck,  m_st == 0, "R3 subck_en");
    chk(vsg,    m_st != 1, "R3 vsg_en");
    chk(vsgr,   m_st == 2, "R3 vsg_readout");
    chk(strobe, m_strobe, m_act_m[0] ? "R5/R11 strobe" : "R8 strobe");
    chk(mshut,  m_mshut,  m_act_m[1] ? "R6 mshut" : "R8 mshut");
    chk(vsub,   m_vsub,   m_act_m[2] ? "R7 vsub" : "R8 vsub");
  endtask

  task automatic step(input logic v, input logic h, input int p,
                      input logic w, input int a, input logic [22:0] d);
    vd = v; hd = h; pix = 12'(p); we = w; addr = 4'(a); data = d;
    @(posedge clk);
    model_edge(v, h, p, w, a, d);
    @(negedge clk);
    compare_all();
  endtask

  task automatic wr(input int a, input logic [22:0] d);
    step(1'b0, 1'b0, IDLE_PIX, 1'b1, a, d);
  endtask

  // one field; optionally a register write before line wl
  task automatic field_w(input int wl, input int a, input logic [22:0] d);
    for (int l = 0; l < NL; l++) begin
      if (l == wl) wr(a, d);
      for (int p = 0; p < NP; p++) begin
        logic lastp, lastl;
        lastp = (p == NP - 1);
        lastl = (l == NL - 1);
        step(lastp && lastl, lastp && !lastl, p, 1'b0, 0, '0);
      end
    end
  endtask

  task automatic field();
    field_w(-1, 0, '0);
  endtask

  task automatic run_vec(input vec_t v);
    int nf;
    wr(0, 23'(v.e));
    wr(1, 23'(v.r));
    wr(3, pos8(v.son));
    wr(4, pos8(v.soff));
    wr(5, pos8(v.shc));
    wr(6, pos8(v.von));
    wr(7, 23'(v.md));
    wr(2, 23'(v.m));
    chk(busy, 1'b0, "R1 trigger waits for field edge");
    field();
    chk(busy, 1'b1, "R2 busy after start");
    chk(subck, 1'b0, "R2 subck gated");
    chk(vsg, 1'b0, "R2 vsg gated");
    nf = max1(int'(v.e)) + max1(int'(v.r));
    repeat (nf) field();
    chk(busy, 1'b0, "R4 idle after readout");
    chk(subck, 1'b1, "R4 subck resumes");
    chk(vsub, 1'b0, "R4 vsub released");
    wr(8, '0);
    field();
    chk(mshut, 1'b1, "R6 shutter reopened");
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    chk(busy,   1'b0, "R10 busy");
    chk(subck,  1'b1, "R10 subck_en");
    chk(vsg,    1'b1, "R10 vsg_en");
    chk(vsgr,   1'b0, "R10 vsg_readout");
    chk(strobe, 1'b0, "R10 strobe");
    chk(mshut,  1'b1, "R10 mshut");
    chk(vsub,   1'b0, "R10 vsub");
    field();

    for (int i = 0; i < 4; i++) run_vec(VECS[i]);

    // R9: trigger during a capture is dropped; shutter stays closed after it
    wr(0, 23'd2);
    wr(1, 23'd1);
    wr(2, 23'd7);
    field();
    chk(busy, 1'b1, "R2 second start");
    field_w(1, 2, 23'd1);
    repeat (2) field();
    chk(busy, 1'b0, "R4 end of second capture");
    field();
    chk(busy, 1'b0, "R9 no restart from trigger written while busy");
    chk(mshut, 1'b0, "R6 stays closed after capture");
    wr(8, '0);
    chk(mshut, 1'b0, "R1 reopen waits for field edge");
    field();
    chk(mshut, 1'b1, "R6 reopen applied at field edge");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule